// File: doc/BRIEF.md
# Monitor Channel Transmit Controller

This block lets a CPU send monitor-channel bytes on up to four independent serial line ports. Each port has a 16-bit control word on a simple register bus. The word holds a data byte, a Ready flag and a Last flag. When Ready is set, the port's serializer takes the byte on that port's next slot strobe and shifts it out MSB first. It then samples the far end's acknowledge in one window cycle.

Setting Last together with Ready turns the next slot into an end-of-message. The serializer sends an all-ones code in place of the data byte. The controller then clears both flags by itself. An acknowledged byte clears Ready and sets a sticky per-port status bit. Each status bit can be enabled onto a single interrupt line. A slot with nothing pending sends all ones.

Software writes a byte with Ready set, waits for the interrupt, clears the status bit and writes the next byte. At the end of the message it writes Last with Ready.

Top module: `mon_tx_ctrl`

## Requirements
- R1: After hardware reset, or after a one-cycle `soft_clr` pulse, every register reads 0, every `tx_bit` is 1 and `irq` is 0.
- R2: Port p's control word is at word index p. Its fields are: data byte in bits 7:0, Ready in bit 8, Last in bit 9. Bits 15:10 read as 0 whatever was written.
- R3: A slot strobe with Ready=1 and Last=0 loads the data byte. `tx_bit` then shows bits 7 down to 0, one per clock, in the 8 cycles after the strobe edge.
- R4: `far_ack` is sampled only in the one cycle after the eighth bit. If it is high there, Ready clears. If it is low, Ready stays set and the same byte goes out on the next slot.
- R5: With Ready=1 and Last=1, the slot sends 0xFF whatever the data byte holds. Afterwards Last and Ready both read 0, whether or not the far end acknowledged.
- R6: A CPU write that changes Last from 1 to 0 also clears Ready, whatever Ready value the write carries.
- R7: A write to the data byte while a slot is in progress leaves the byte on the line unchanged. The new value goes out from the next slot.
- R8: A slot with Ready=0 sends 0xFF and changes no register, including when Last is set alone.
- R9: Status bits (word index 9, bit p = port p) set on an acknowledged slot and stay set until written with 1. Enable bits are at word index 8. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R10: A slot strobe that arrives while that port's slot is still in progress is ignored.
- R11: Ports run independently. Strobes on several ports in one cycle each send that port's own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of all state |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| slot_strobe | input | NPORTS (4) | Start of a monitor slot, per port |
| far_ack | input | NPORTS (4) | Far-end acknowledge, per port |
| tx_bit | output | NPORTS (4) | Serial monitor bit, per port; idle 1 |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
Assertions check on every cycle how the flags respond to the serializer's finish pulses and to a write that drops Last. They also check the code loaded for end-of-message and idle slots, the MSB-first shift order, that status bits are sticky, and that reserved read bits are zero. Only the bench's scenarios can show the following:
- a refused byte being resent;
- a data write during a slot taking effect only on the next slot;
- a second strobe during a busy slot being lost;
- interrupt masking;
- ports working in parallel.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
   localparam int REG_W  = 16;   // control word width
   localparam int IE_IDX = 8;    // word index of enable register
   localparam int ST_IDX = 9;    // word index of status register
   localparam int MAX_PORTS = 8;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_SHIFT = 2'd1,
      S_ACKW  = 2'd2
   } ser_state_t;
endpackage

// File: rtl/mon_tx_port_reg.sv
module mon_tx_port_reg #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic          wr_en,
   input  logic [BW+1:0] wdata,
   input  logic          fin_ack,
   input  logic          fin_eom,
   output logic [BW-1:0] data,
   output logic          ready,
   output logic          last
);
   localparam int RB = BW;
   localparam int LB = BW + 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         ready <= 1'b0;
         last  <= 1'b0;
      end else if (soft_clr) begin
         data  <= '0;
         ready <= 1'b0;
         last  <= 1'b0;
      end else if (wr_en) begin
         data  <= wdata[BW-1:0];
         last  <= wdata[LB];
         ready <= wdata[RB] & ~(last & ~wdata[LB]);
      end else begin
         if (fin_eom) begin
            last  <= 1'b0;
            ready <= 1'b0;
         end
         if (fin_ack) ready <= 1'b0;
      end
   end

   p_ack_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (fin_ack && !wr_en) |=> !ready);
   p_eom_clears_flags_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (fin_eom && !wr_en) |=> (!ready && !last));
   p_last_drop_r6: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (wr_en && last && !wdata[LB]) |=> !ready);
endmodule

// File: rtl/mon_tx_port_ser.sv
module mon_tx_port_ser
   import mon_tx_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic          strobe,
   input  logic          ready,
   input  logic          last,
   input  logic [BW-1:0] data,
   input  logic          ack,
   output logic          tx_bit,
   output logic          fin_ack,
   output logic          fin_eom
);
   localparam int CW = $clog2(BW);
   localparam logic [CW-1:0] CNT_END = CW'(BW - 1);

   ser_state_t    state;
   logic [BW-1:0] shreg;
   logic [CW-1:0] cnt;
   logic          is_data, is_eom;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; shreg <= '1; cnt <= '0;
         is_data <= 1'b0; is_eom <= 1'b0;
      end else if (soft_clr) begin
         state <= S_IDLE; shreg <= '1; cnt <= '0;
         is_data <= 1'b0; is_eom <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (strobe) begin
               shreg   <= (ready && !last) ? data : '1;
               is_data <= ready & ~last;
               is_eom  <= ready & last;
               cnt     <= '0;
               state   <= S_SHIFT;
            end
            S_SHIFT: if (cnt == CNT_END) begin
               state <= S_ACKW;
            end else begin
               cnt   <= cnt + 1'b1;
               shreg <= {shreg[BW-2:0], 1'b1};
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign tx_bit  = (state == S_SHIFT) ? shreg[BW-1] : 1'b1;
   assign fin_ack = (state == S_ACKW) && ack && (is_data || is_eom);
   assign fin_eom = (state == S_ACKW) && is_eom;

   p_eom_code_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (state == S_IDLE && strobe && ready && last) |=> (shreg == '1));
   p_idle_fill_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (state == S_IDLE && strobe && !ready) |=> (shreg == '1));
   p_shift_order_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (state == S_SHIFT && cnt != CNT_END) |=> (tx_bit == $past(shreg[BW-2])));
endmodule

// File: rtl/mon_tx_ctrl.sv
module mon_tx_ctrl
   import mon_tx_pkg::*;
#(
   parameter int NPORTS  = 4,
   parameter int BW      = 8,
   parameter int AW      = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [NPORTS-1:0] slot_strobe,
   input  logic [NPORTS-1:0] far_ack,
   output logic [NPORTS-1:0] tx_bit,
   output logic              irq
);
   localparam int FW = BW + 2;

   if (NPORTS < 1 || NPORTS > MAX_PORTS) begin : g_bad_ports
      $error("NPORTS must be 1..%0d", MAX_PORTS);
   end
   if (BW < 2 || FW > REG_W) begin : g_bad_bw
      $error("BW must leave room for two flags in the control word");
   end
   if (AW < 4) begin : g_bad_aw
      $error("AW too small for the register map");
   end

   logic [NPORTS-1:0] fin_ack, fin_eom, rdy, lst, ie, st;
   logic [BW-1:0]     dat [NPORTS];
   logic              st_wr, ie_wr;
   logic              wdata_unused;

   assign wdata_unused = ^bus_wdata[REG_W-1:FW];
   assign st_wr = bus_wr && (bus_addr == AW'(ST_IDX));
   assign ie_wr = bus_wr && (bus_addr == AW'(IE_IDX));

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic wr_ctl;
      assign wr_ctl = bus_wr && (bus_addr == AW'(p));

      mon_tx_port_reg #(.BW(BW)) u_reg (
         .clk, .rst_n, .soft_clr,
         .wr_en(wr_ctl), .wdata(bus_wdata[FW-1:0]),
         .fin_ack(fin_ack[p]), .fin_eom(fin_eom[p]),
         .data(dat[p]), .ready(rdy[p]), .last(lst[p]));

      mon_tx_port_ser #(.BW(BW)) u_ser (
         .clk, .rst_n, .soft_clr,
         .strobe(slot_strobe[p]), .ready(rdy[p]), .last(lst[p]),
         .data(dat[p]), .ack(far_ack[p]),
         .tx_bit(tx_bit[p]), .fin_ack(fin_ack[p]), .fin_eom(fin_eom[p]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie <= '0; st <= '0;
      end else if (soft_clr) begin
         ie <= '0; st <= '0;
      end else begin
         if (ie_wr) ie <= bus_wdata[NPORTS-1:0];
         for (int p = 0; p < NPORTS; p++) begin
            if (fin_ack[p])                  st[p] <= 1'b1;
            else if (st_wr && bus_wdata[p])  st[p] <= 1'b0;
         end
      end
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        irq <= 1'b0;
         else if (soft_clr) irq <= 1'b0;
         else               irq <= |(st & ie);
      end
   end else begin : g_irq_comb
      assign irq = |(st & ie);
   end

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NPORTS; p++) begin
         if (bus_addr == AW'(p)) bus_rdata[FW-1:0] = {lst[p], rdy[p], dat[p]};
      end
      if (bus_addr == AW'(IE_IDX)) bus_rdata[NPORTS-1:0] = ie;
      if (bus_addr == AW'(ST_IDX)) bus_rdata[NPORTS-1:0] = st;
   end

   p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      !st_wr |=> ((st & $past(st)) == $past(st)));
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (bus_addr < AW'(NPORTS)) |-> (bus_rdata[REG_W-1:FW] == '0));
endmodule

// File: tb/mon_tx_ctrl_bench.sv
`timescale 1ns/1ps
module mon_tx_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_clr = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  slot_strobe = '0;
   logic [3:0]  far_ack = '0;
   logic [3:0]  tx_bit;
   logic        irq;

   int errs = 0;
   int chks = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] b; string tag; } item_t;
   item_t q [4][$];

   logic [7:0] m_data [4];
   logic [3:0] m_ready = '0, m_last = '0, m_ie = '0, m_st = '0;

   always #2.5 clk = ~clk;

   mon_tx_ctrl u_mon_tx_ctrl (
      .clk, .rst_n, .soft_clr, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .slot_strobe, .far_ack, .tx_bit, .irq);

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      chks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a < 4) begin
         m_ready[a] = d[8] & ~(m_last[a] & ~d[9]);
         m_last[a]  = d[9];
         m_data[a]  = d[7:0];
      end else if (a == 8) m_ie = d[3:0];
      else if (a == 9) m_st = m_st & ~d[3:0];
   endtask

   task automatic rd_chk(input int a, input string tag);
      logic [15:0] exp;
      if (a < 4)       exp = {6'b0, m_last[a], m_ready[a], m_data[a]};
      else if (a == 8) exp = {12'b0, m_ie};
      else             exp = {12'b0, m_st};
      @(negedge clk);
      bus_addr = 4'(a);
      #1;
      check(bus_rdata, exp, tag);
   endtask

   task automatic irq_chk(input string tag);
      @(negedge clk);
      check({15'b0, irq}, {15'b0, |(m_st & m_ie)}, tag);
   endtask

   // driver: pushes expected bytes, pulses strobes, then updates the model
   task automatic slots(input logic [3:0] mask, input logic [3:0] ackv, input bit dbl,
                        input int midp, input logic [15:0] midv, input string tag);
      logic [3:0] r0, l0;
      r0 = m_ready; l0 = m_last;
      for (int p = 0; p < 4; p++) begin
         if (mask[p]) begin
            item_t it;
            it.b = m_ready[p] ? (m_last[p] ? 8'hFF : m_data[p]) : 8'hFF;
            it.tag = tag;
            q[p].push_back(it);
         end
      end
      @(negedge clk);
      far_ack = ackv; slot_strobe = mask;
      @(negedge clk);
      slot_strobe = '0;
      if (dbl) begin
         @(negedge clk);
         slot_strobe = mask;
         @(negedge clk);
         slot_strobe = '0;
      end
      if (midp >= 0) wr(midp, midv);
      repeat (14) @(negedge clk);
      far_ack = '0;
      for (int p = 0; p < 4; p++) begin
         if (mask[p] && r0[p]) begin
            if (l0[p]) begin
               m_ready[p] = 1'b0; m_last[p] = 1'b0;
               if (ackv[p]) m_st[p] = 1'b1;
            end else if (ackv[p]) begin
               m_ready[p] = 1'b0; m_st[p] = 1'b1;
            end
         end
         if (mask[p]) check(16'(q[p].size()), 16'd0, {tag, " slot seen"});
      end
   endtask

   // monitor: one per port, captures 8 bits after a strobe and compares
   for (genvar g = 0; g < 4; g++) begin : g_mon
      initial begin
         forever begin
            @(posedge clk);
            if (rst_n && slot_strobe[g]) begin
               logic [7:0] got;
               for (int i = 7; i >= 0; i--) begin
                  @(negedge clk);
                  got[i] = tx_bit[g];
               end
               chks++;
               if (q[g].size() == 0) begin
                  errs++;
                  $display("FAIL R10: port %0d unexpected slot got %h expected none", g, got);
               end else begin
                  item_t it;
                  it = q[g].pop_front();
                  if (got !== it.b) begin
                     errs++;
                     $display("FAIL %s: port %0d line got %h expected %h", it.tag, g, got, it.b);
                  end
               end
               repeat (2) @(posedge clk);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; chks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, chks);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 4; p++) m_data[p] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) rd_chk(a, "R1 reset ctrl");
      rd_chk(8, "R1 reset ie");
      rd_chk(9, "R1 reset status");
      @(negedge clk);
      check({12'b0, tx_bit}, 16'h000F, "R1 idle line");
      irq_chk("R1 irq");

      // R2 layout and reserved bits
      wr(1, 16'hFFFF);
      rd_chk(1, "R2 reserved read zero");
      wr(1, 16'h0000);
      rd_chk(1, "R2 cleared");

      // R3/R4 send, refused then accepted
      wr(0, 16'h01A5);
      slots(4'b0001, 4'b0000, 0, -1, 0, "R3 data byte");
      rd_chk(0, "R4 no ack keeps ready");
      slots(4'b0001, 4'b0001, 0, -1, 0, "R4 resend");
      rd_chk(0, "R4 ack clears ready");
      rd_chk(9, "R9 status set");
      irq_chk("R9 masked irq");
      wr(8, 16'h0001);
      irq_chk("R9 enabled irq");
      wr(9, 16'h0001);
      rd_chk(9, "R9 write one clears");
      irq_chk("R9 irq after clear");

      // R8 idle slots
      slots(4'b0001, 4'b0001, 0, -1, 0, "R8 idle all ones");
      rd_chk(9, "R8 idle no status");
      wr(2, 16'h0233);
      slots(4'b0100, 4'b0100, 0, -1, 0, "R8 last alone idle");
      rd_chk(2, "R8 last alone kept");

      // R5 end of message without ack
      wr(2, 16'h0333);
      slots(4'b0100, 4'b0000, 0, -1, 0, "R5 eom code");
      rd_chk(2, "R5 flags cleared");
      rd_chk(9, "R5 no ack no status");

      // R6 dropping Last clears Ready
      wr(3, 16'h035A);
      wr(3, 16'h015A);
      rd_chk(3, "R6 ready cleared");

      // R7 data write mid-slot
      wr(3, 16'h0111);
      slots(4'b1000, 4'b0000, 0, 3, 16'h0122, "R7 old byte kept");
      slots(4'b1000, 4'b1000, 0, -1, 0, "R7 new byte next slot");
      rd_chk(3, "R7 ready cleared");

      // R10 strobe while busy
      wr(1, 16'h0196);
      slots(4'b0010, 4'b0010, 1, -1, 0, "R10 single byte");
      rd_chk(1, "R10 ready cleared");

      // R11 parallel ports, irq on port 3
      wr(8, 16'h0008);
      wr(9, 16'h000F);
      wr(0, 16'h01C3);
      wr(3, 16'h013C);
      slots(4'b1001, 4'b1001, 0, -1, 0, "R11 parallel");
      rd_chk(9, "R11 both status");
      irq_chk("R11 irq port3");

      // R1 soft clear
      wr(2, 16'h0177);
      @(negedge clk);
      soft_clr = 1'b1;
      @(negedge clk);
      soft_clr = 1'b0;
      m_ready = '0; m_last = '0; m_ie = '0; m_st = '0;
      for (int p = 0; p < 4; p++) m_data[p] = '0;
      for (int a = 0; a < 4; a++) rd_chk(a, "R1 soft clear ctrl");
      rd_chk(8, "R1 soft clear ie");
      rd_chk(9, "R1 soft clear status");
      irq_chk("R1 soft clear irq");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end
endmodule